// File: doc/BRIEF.md
# Data Processing ALU With Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes a first operand from the register file and a second operand that has already passed through the barrel shifter. It also takes the shifter's carry-out, the current carry and overflow flags, a 4-bit operation code and a set-flags bit. It produces the result word, a strobe saying whether that result is written back, and the next values of the negative, zero, carry and overflow flags, together with a strobe saying whether the flags are committed.

Sixteen operations are supported: six arithmetic forms (plain, with carry-in, and operand-reversed subtraction), four bitwise forms, two moves, and four compare-style forms that only set flags. The flag rules depend on the operation: arithmetic forms produce a true carry and signed overflow, while bitwise forms and moves take the carry from the shifter and keep the current overflow. A parameter chooses between a purely combinational path and a single output register.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic codes give: 0100 op1+op2, 0101 op1+op2+Cin, 0010 op1-op2, 0110 op1-op2+Cin-1, 0011 op2-op1, 0111 op2-op1+Cin-1, all modulo 2^32.
- R2: Bitwise codes give: 0000 op1&op2, 0001 op1^op2, 1100 op1|op2, 1110 op1&~op2; 1101 gives op2 and 1111 gives ~op2, with op1 having no effect on those two.
- R3: The compare codes 1000 (AND), 1001 (XOR), 1010 (subtract), 1011 (add) drive the result write strobe low and the flag strobe high whatever the set-flags bit is.
- R4: Every other code drives the result write strobe high and the flag strobe equal to the set-flags bit.
- R5: The next N flag equals bit 31 of the computed value and the next Z flag is 1 exactly when the computed value is all zeros, compare codes included.
- R6: For arithmetic and arithmetic compare codes the next C flag is the carry out of bit 31; for subtractions this is the inverted borrow (1 when no borrow occurs).
- R7: For arithmetic and arithmetic compare codes the next V flag is 1 exactly when the two's complement result does not fit in 32 bits.
- R8: For bitwise, move and bitwise compare codes the next C flag equals the shifter carry-out input and the next V flag equals the current V input.
- R9: With the output register enabled (default), all outputs appear one clock after their inputs and are all zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| op1 | input | 32 | First operand, from the register file |
| op2 | input | 32 | Second operand, after the shifter |
| shCarry | input | 1 | Carry-out of the shifter |
| cIn | input | 1 | Current C flag |
| vIn | input | 1 | Current V flag |
| opcode | input | 4 | Operation code |
| setFlags | input | 1 | Request to update flags |
| result | output | 32 | Computed value |
| resWrEn | output | 1 | Result is to be written back |
| nNext | output | 1 | Next N flag |
| zNext | output | 1 | Next Z flag |
| cNext | output | 1 | Next C flag |
| vNext | output | 1 | Next V flag |
| flagWrEn | output | 1 | Flags are to be committed |

## Verification
The hardest situations to reach are the carry-in subtractions at their borrow boundary, where op1 equals op2 and the incoming carry alone decides whether a borrow occurs, and signed overflow at the most negative value. Random operands almost never reach these, so directed vectors put equal operands, 0x80000000 and 0x7FFFFFFF into every arithmetic code with both carry values. Long random runs then sweep all sixteen codes with random carry, overflow and shifter inputs against a reference that works in wide signed and unsigned integers.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_CFLAG = 2'd2
  } cinSel_e;

  typedef enum logic [1:0] {
    LOG_AND  = 2'd0,
    LOG_XOR  = 2'd1,
    LOG_OR   = 2'd2,
    LOG_PASS = 2'd3
  } logSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    useAdder;
    logic    invA;
    logic    invB;
    cinSel_e cinSel;
    logSel_e logSel;
    logic    invLogB;
    logic    writeRes;
    logic    updFlags;
  } aluCtrl_t;

endpackage

// File: rtl/dp_alu_ctrl.sv
module dp_alu_ctrl
  import dp_alu_pkg::*;
(
  input  logic [3:0] opcode,
  input  logic       setFlags,
  output aluCtrl_t   ctrl
);

  aluOp_e op;
  assign op = aluOp_e'(opcode);

  always_comb begin
    ctrl          = '0;
    ctrl.cinSel   = CIN_ZERO;
    ctrl.logSel   = LOG_AND;
    ctrl.writeRes = 1'b1;
    ctrl.updFlags = setFlags;
    unique case (op)
      OP_ADD: ctrl.useAdder = 1'b1;
      OP_ADC: begin ctrl.useAdder = 1'b1; ctrl.cinSel = CIN_CFLAG; end
      OP_SUB: begin ctrl.useAdder = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_SBC: begin ctrl.useAdder = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_CFLAG; end
      OP_RSB: begin ctrl.useAdder = 1'b1; ctrl.invA = 1'b1; ctrl.cinSel = CIN_ONE; end
      OP_RSC: begin ctrl.useAdder = 1'b1; ctrl.invA = 1'b1; ctrl.cinSel = CIN_CFLAG; end
      OP_AND: ctrl.logSel = LOG_AND;
      OP_EOR: ctrl.logSel = LOG_XOR;
      OP_ORR: ctrl.logSel = LOG_OR;
      OP_BIC: begin ctrl.logSel = LOG_AND; ctrl.invLogB = 1'b1; end
      OP_MOV: ctrl.logSel = LOG_PASS;
      OP_MVN: begin ctrl.logSel = LOG_PASS; ctrl.invLogB = 1'b1; end
      OP_TST: begin ctrl.logSel = LOG_AND; ctrl.writeRes = 1'b0; ctrl.updFlags = 1'b1; end
      OP_TEQ: begin ctrl.logSel = LOG_XOR; ctrl.writeRes = 1'b0; ctrl.updFlags = 1'b1; end
      OP_CMP: begin
        ctrl.useAdder = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
        ctrl.writeRes = 1'b0; ctrl.updFlags = 1'b1;
      end
      OP_CMN: begin
        ctrl.useAdder = 1'b1; ctrl.writeRes = 1'b0; ctrl.updFlags = 1'b1;
      end
      default: ctrl.writeRes = 1'b1;
    endcase
  end

endmodule

// File: rtl/dp_alu_path.sv
module dp_alu_path
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [WIDTH-1:0]  op1,
  input  logic [WIDTH-1:0]  op2,
  input  logic              shCarry,
  input  logic              cIn,
  input  logic              vIn,
  output logic [WIDTH-1:0]  value,
  output logic              nFlag,
  output logic              zFlag,
  output logic              cFlag,
  output logic              vFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addA, addB, sum, logB, logVal;
  logic [WIDTH:0]   wideSum;
  logic             carryIn, addOvf;

  // Adder operand preparation
  assign addA = ctrl.invA ? ~op1 : op1;
  assign addB = ctrl.invB ? ~op2 : op2;

  always_comb begin
    unique case (ctrl.cinSel)
      CIN_ONE:   carryIn = 1'b1;
      CIN_CFLAG: carryIn = cIn;
      default:   carryIn = 1'b0;
    endcase
  end

  assign wideSum = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn};
  assign sum     = wideSum[MSB:0];
  assign addOvf  = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);

  // Bitwise unit
  assign logB = ctrl.invLogB ? ~op2 : op2;

  always_comb begin
    unique case (ctrl.logSel)
      LOG_XOR:  logVal = op1 ^ logB;
      LOG_OR:   logVal = op1 | logB;
      LOG_PASS: logVal = logB;
      default:  logVal = op1 & logB;
    endcase
  end

  assign value = ctrl.useAdder ? sum : logVal;
  assign nFlag = value[MSB];
  assign zFlag = (value == '0);
  assign cFlag = ctrl.useAdder ? wideSum[WIDTH] : shCarry;
  assign vFlag = ctrl.useAdder ? addOvf : vIn;

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] op1,
  input  logic [WIDTH-1:0] op2,
  input  logic             shCarry,
  input  logic             cIn,
  input  logic             vIn,
  input  logic [3:0]       opcode,
  input  logic             setFlags,
  output logic [WIDTH-1:0] result,
  output logic             resWrEn,
  output logic             nNext,
  output logic             zNext,
  output logic             cNext,
  output logic             vNext,
  output logic             flagWrEn
);

  localparam int OUTW = WIDTH + 6;

  aluCtrl_t         ctrl;
  logic [WIDTH-1:0] value;
  logic             nF, zF, cF, vF;
  logic [OUTW-1:0]  combOut, outBus;

  dp_alu_ctrl u_ctrl (
    .opcode  (opcode),
    .setFlags(setFlags),
    .ctrl    (ctrl)
  );

  dp_alu_path #(.WIDTH(WIDTH)) u_path (
    .ctrl   (ctrl),
    .op1    (op1),
    .op2    (op2),
    .shCarry(shCarry),
    .cIn    (cIn),
    .vIn    (vIn),
    .value  (value),
    .nFlag  (nF),
    .zFlag  (zF),
    .cFlag  (cF),
    .vFlag  (vF)
  );

  assign combOut = {value, ctrl.writeRes, nF, zF, cF, vF, ctrl.updFlags};

  generate
    if (REG_OUT) begin : g_reg
      logic [OUTW-1:0] outQ;
      always_ff @(posedge clk) begin
        if (!rstN) outQ <= '0;
        else       outQ <= combOut;
      end
      assign outBus = outQ;
    end else begin : g_comb
      assign outBus = combOut;
    end
  endgenerate

  assign {result, resWrEn, nNext, zNext, cNext, vNext, flagWrEn} = outBus;

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] op1,
  input logic [WIDTH-1:0] op2,
  input logic             shCarry,
  input logic             cIn,
  input logic             vIn,
  input logic [3:0]       opcode,
  input logic             setFlags,
  input logic [WIDTH-1:0] result,
  input logic             resWrEn,
  input logic             nNext,
  input logic             zNext,
  input logic             cNext,
  input logic             vNext,
  input logic             flagWrEn
);

  logic [WIDTH-1:0] dOp2;
  logic [3:0]       dOpc;
  logic             dSh, dV, dS, seen;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dOp2 <= '0; dOpc <= '0; dSh <= 1'b0; dV <= 1'b0; dS <= 1'b0; seen <= 1'b0;
        end else begin
          dOp2 <= op2; dOpc <= opcode; dSh <= shCarry; dV <= vIn; dS <= setFlags;
          seen <= 1'b1;
        end
      end
    end else begin : g_now
      assign dOp2 = op2;
      assign dOpc = opcode;
      assign dSh  = shCarry;
      assign dV   = vIn;
      assign dS   = setFlags;
      assign seen = 1'b1;
    end
  endgenerate

  logic isCompare, isBitwise;
  assign isCompare = (dOpc[3:2] == 2'b10);
  assign isBitwise = (dOpc == 4'b0000) || (dOpc == 4'b0001) || (dOpc == 4'b1000) ||
                     (dOpc == 4'b1001) || (dOpc[3:2] == 2'b11);

  a_r3_compare_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (seen && isCompare) |-> (!resWrEn && flagWrEn));

  a_r4_flag_follows_s: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !isCompare) |-> (resWrEn && (flagWrEn == dS)));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (zNext == (result == '0)));

  a_r5_neg_flag: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (nNext == result[WIDTH-1]));

  a_r8_bitwise_flags: assert property (@(posedge clk) disable iff (!rstN)
    (seen && isBitwise) |-> ((cNext == dSh) && (vNext == dV)));

  a_r2_move_passes: assert property (@(posedge clk) disable iff (!rstN)
    (seen && dOpc == 4'b1101) |-> (result == dOp2));

  a_r9_reset_clear: assert property (@(posedge clk)
    (REG_OUT && !rstN) |=> (!rstN |-> (result == '0 && !resWrEn && !flagWrEn)));

endmodule

bind dp_alu dp_alu_checker #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

  typedef struct {
    logic [31:0] res;
    logic rw, n, z, c, v, fw;
    logic [3:0] opc;
  } expect_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] op1 = '0, op2 = '0;
  logic        shCarry = 1'b0, cIn = 1'b0, vIn = 1'b0, setFlags = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] result;
  logic        resWrEn, nNext, zNext, cNext, vNext, flagWrEn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  expect_t pending[$];

  always #2.5 clk = ~clk;

  dp_alu u_dp_alu (
    .clk(clk), .rstN(rstN), .op1(op1), .op2(op2), .shCarry(shCarry), .cIn(cIn),
    .vIn(vIn), .opcode(opcode), .setFlags(setFlags), .result(result),
    .resWrEn(resWrEn), .nNext(nNext), .zNext(zNext), .cNext(cNext),
    .vNext(vNext), .flagWrEn(flagWrEn)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference using wide integers
  function automatic expect_t model(input logic [3:0] opc, input logic [31:0] a,
                                    input logic [31:0] b, input logic sc,
                                    input logic ci, input logic vi, input logic s);
    expect_t e;
    longint ua, ub, sa, sb, u, sr;
    bit arith, isSub;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    arith = 1'b1; isSub = 1'b0; u = 0; sr = 0;
    e.opc = opc;
    case (opc)
      4'b0100, 4'b1011: begin u = ua + ub;      sr = sa + sb; end
      4'b0101: begin u = ua + ub + ci;          sr = sa + sb + ci; end
      4'b0010, 4'b1010: begin u = ua - ub;      sr = sa - sb;      isSub = 1'b1; end
      4'b0110: begin u = ua - ub - (1 - ci);    sr = sa - sb - (1 - ci); isSub = 1'b1; end
      4'b0011: begin u = ub - ua;               sr = sb - sa;      isSub = 1'b1; end
      4'b0111: begin u = ub - ua - (1 - ci);    sr = sb - sa - (1 - ci); isSub = 1'b1; end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      e.res = u[31:0];
      e.c = isSub ? (u >= 0) : (u > 64'sh0FFFF_FFFF);
      e.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (opc)
        4'b0000, 4'b1000: e.res = a & b;
        4'b0001, 4'b1001: e.res = a ^ b;
        4'b1100: e.res = a | b;
        4'b1110: e.res = a & ~b;
        4'b1101: e.res = b;
        default: e.res = ~b;
      endcase
      e.c = sc;
      e.v = vi;
    end
    e.n  = e.res[31];
    e.z  = (e.res == 32'd0);
    e.rw = (opc[3:2] != 2'b10);
    e.fw = (opc[3:2] == 2'b10) ? 1'b1 : s;
    return e;
  endfunction

  function automatic bit isArith(input logic [3:0] opc);
    return (opc[3:2] == 2'b01) || (opc == 4'b0010) || (opc == 4'b0011) ||
           (opc == 4'b1010) || (opc == 4'b1011);
  endfunction

  task automatic compare(input expect_t e);
    string rRes, rC, rV, rW;
    rRes = isArith(e.opc) ? "R1" : "R2";
    rC   = isArith(e.opc) ? "R6" : "R8";
    rV   = isArith(e.opc) ? "R7" : "R8";
    rW   = (e.opc[3:2] == 2'b10) ? "R3" : "R4";
    check(rRes, "result", result, e.res);
    check(rW, "resWrEn", 32'(resWrEn), 32'(e.rw));
    check(rW, "flagWrEn", 32'(flagWrEn), 32'(e.fw));
    check("R5", "N", 32'(nNext), 32'(e.n));
    check("R5", "Z", 32'(zNext), 32'(e.z));
    check(rC, "C", 32'(cNext), 32'(e.c));
    check(rV, "V", 32'(vNext), 32'(e.v));
  endtask

  // Called at a negedge: check previous vector, then drive the next
  task automatic apply(input logic [3:0] opc, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic ci, input logic vi, input logic s);
    logic [31:0] held;
    if (pending.size() > 0) compare(pending.pop_front());
    held = result;
    opcode = opc; op1 = a; op2 = b; shCarry = sc; cIn = ci; vIn = vi; setFlags = s;
    pending.push_back(model(opc, a, b, sc, ci, vi, s));
    #1;
    check("R9", "output held until next edge", result, held);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset result", result, 32'd0);
    check("R9", "reset write strobes", 32'({resWrEn, flagWrEn}), 32'd0);
    check("R9", "reset flags", 32'({nNext, zNext, cNext, vNext}), 32'd0);
    rstN = 1'b1;

    // R1/R6/R7 boundaries
    apply(4'b0100, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 1);
    apply(4'b0100, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 1);
    apply(4'b0101, 32'hFFFF_FFFF, 32'h0, 0, 1, 0, 1);
    apply(4'b0010, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 1);
    apply(4'b0010, 32'h0, 32'h1, 0, 0, 0, 1);
    apply(4'b0010, 32'h8000_0000, 32'h1, 0, 0, 0, 1);
    for (int cc = 0; cc < 2; cc++) begin
      apply(4'b0110, 32'h55, 32'h55, 0, 1'(cc), 0, 1);
      apply(4'b0111, 32'h8000_0000, 32'h8000_0000, 0, 1'(cc), 0, 1);
      apply(4'b0011, 32'h7FFF_FFFF, 32'h8000_0000, 0, 1'(cc), 1'(cc), 1);
    end
    // R3 compares with S low
    apply(4'b1010, 32'h5, 32'h5, 0, 0, 0, 0);
    apply(4'b1011, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0);
    apply(4'b1000, 32'hF0F0_0000, 32'h0F0F_FFFF, 1, 0, 1, 0);
    apply(4'b1001, 32'hABCD, 32'hABCD, 0, 1, 0, 0);
    // R2 moves ignore op1, R8 bitwise flags
    apply(4'b1101, 32'hDEAD_BEEF, 32'h0000_1234, 1, 0, 1, 1);
    apply(4'b1101, 32'h0, 32'h0000_1234, 0, 1, 0, 1);
    apply(4'b1111, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 1);
    apply(4'b1111, 32'h1, 32'h0, 1, 0, 0, 1);
    apply(4'b1110, 32'hFFFF_FFFF, 32'h0000_FF00, 0, 1, 1, 1);
    apply(4'b1100, 32'h0, 32'h0, 1, 0, 1, 0);
    apply(4'b0000, 32'h8000_0001, 32'hFFFF_FFFF, 0, 1, 1, 1);
    // R4 S low on result-writing ops
    apply(4'b0100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    apply(4'b0001, 32'hFF00, 32'h0FF0, 1, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = {a[31], 31'h7FFF_FFFF};
      apply(4'($urandom), a, b, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    if (pending.size() > 0) compare(pending.pop_front());
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule